// File: doc/BRIEF.md
# Shared Bus Ownership Arbiter

This block decides which of five masters drives a single shared external bus: a memory refresh requester, an outside device asking for the bus, a two-channel network DMA engine, a two-channel general DMA controller, and the CPU. The CPU keeps the bus whenever nobody else wants it. A new owner is chosen only on a clock edge where the current bus cycle has ended and no lock is held. The lock covers burst fills, block transfers and indivisible read-modify-write pairs. The block also names the channel that gets the tenure inside each DMA engine.

When the outside device wins, the block first forces the control strobes to their inactive level and releases the output enables. It then acknowledges on an active-low line. After the device lets go, the block drives the bus again, starting from the inactive strobe level. Bus timing, memory protocol and address generation live outside the block and are seen only as request, busy and lock inputs.

Top module: `bus_arb_top`

## Requirements
- R1: `grant` is always one-hot, with bit 0 for the CPU, bit 1 for the general DMA, bit 2 for the network DMA, bit 3 for the outside device and bit 4 for refresh. Reset sets `grant`=5'b00001, `ext_ack_n`=1, `bus_oe`=1, `strobe_neg`=0, `edma_ch`=0 and `dma_ch`=0.
- R2: At an arbitration edge the winner among the active requests is, from highest to lowest: refresh, outside device (`ext_req_n` low), network DMA (either bit of `edma_req`), general DMA (either bit of `dma_req`), CPU.
- R3: At an arbitration edge with no request active, `grant` becomes or stays the CPU.
- R4: An arbitration edge is a rising clock edge that samples `bus_busy`=0 and `bus_lock`=0 while the bus is not lent out. The new owner shows at that edge. `grant` never changes at an edge that samples `bus_busy` or `bus_lock` high.
- R5: While `bus_lock` is held for several cycles, `grant`, `edma_ch` and `dma_ch` keep their values, even when a higher-priority request arrives.
- R6: When the network DMA wins, `edma_ch` takes the only requesting channel. If both channels request, it takes the channel opposite to its current value, so successive tenures alternate (0 transmit, 1 receive).
- R7: With `dma_rr_mode`=0, a general DMA win with both channels requesting selects channel 0. With a single requester it selects that channel.
- R8: With `dma_rr_mode`=1, a general DMA win with both channels requesting selects the channel not served last, as held in `dma_ch`.
- R9: The arbitration edge that the outside device wins sets `strobe_neg`=1 and `bus_oe`=0 with `ext_ack_n` still 1. The next edge drives `ext_ack_n` to 0.
- R10: The first edge that samples `ext_req_n` high while acknowledged sets `ext_ack_n`=1 and `bus_oe`=1, and keeps `strobe_neg`=1. `strobe_neg` returns to 0 only after a later arbitration edge picks an internal owner.
- R11: From the win by the outside device until the bus is reclaimed, `grant` stays on the outside device whatever the other requests, `bus_busy` or `bus_lock` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_req | input | 1 | Memory refresh request |
| ext_req_n | input | 1 | Outside device bus request, active low |
| edma_req | input | 2 | Network DMA channel requests (0 transmit, 1 receive) |
| dma_req | input | 2 | General DMA channel requests |
| dma_rr_mode | input | 1 | 0 fixed channel order, 1 rotating order |
| bus_busy | input | 1 | A bus cycle (external or internal idle insertion) is in progress |
| bus_lock | input | 1 | Current owner holds an indivisible sequence |
| grant | output | 5 | One-hot bus owner |
| edma_ch | output | 1 | Network DMA channel of the latest tenure |
| dma_ch | output | 1 | General DMA channel of the latest tenure |
| ext_ack_n | output | 1 | Bus acknowledge to the outside device, active low |
| bus_oe | output | 1 | Chip drives the bus control and data pins |
| strobe_neg | output | 1 | Force bus control strobes to their inactive level |

## Verification
The assertions assume that `bus_busy` and `bus_lock` are set by the current owner's sequencing logic and remain valid on every edge, idle wait cycles included. They also assume that a request which wins is still present at the edge where it is sampled. Requests that are not acted on at that edge carry no meaning for the block. The stimulus changes all inputs only at falling clock edges, so each rising edge samples settled values. Random phases keep the outside request low for runs of several cycles, so that complete handovers and returns occur while busy, lock and the other requests toggle freely.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
   localparam int unsigned OWNER_N  = 5;
   localparam int unsigned IDX_CPU  = 0;
   localparam int unsigned IDX_DMA  = 1;
   localparam int unsigned IDX_EDMA = 2;
   localparam int unsigned IDX_EXT  = 3;
   localparam int unsigned IDX_REF  = 4;

   typedef enum logic [1:0] {
      PH_OWNED   = 2'd0,
      PH_PREP    = 2'd1,
      PH_LENT    = 2'd2,
      PH_RECLAIM = 2'd3
   } phase_e;
endpackage

// File: rtl/bus_arb_prio.sv
module bus_arb_prio #(
   parameter int unsigned N = 5
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] win
);
   logic [N:0] above;
   assign above[N] = 1'b0;

   for (genvar gi = N - 1; gi >= 0; gi--) begin : g_lvl
      assign above[gi] = above[gi+1] | req[gi];
      assign win[gi]   = req[gi] & ~above[gi+1];
   end
endmodule

// File: rtl/bus_arb_pair_sel.sv
module bus_arb_pair_sel #(
   parameter bit ALTERNATE_ONLY = 1'b0,
   parameter bit RESET_CH       = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [1:0] req,
   input  logic       rotate,
   output logic       ch
);
   logic rot_eff;
   logic pick;

   if (ALTERNATE_ONLY) begin : g_alt
      assign rot_eff = 1'b1 | rotate;
   end else begin : g_mode
      assign rot_eff = rotate;
   end

   always_comb begin
      if (req == 2'b11) pick = rot_eff ? ~ch : 1'b0;
      else              pick = req[1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ch <= RESET_CH;
      else if (load) ch <= pick;
   end
endmodule

// File: rtl/bus_arb_ext_fsm.sv
module bus_arb_ext_fsm
   import bus_arb_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   free,
   input  logic   ext_win,
   input  logic   ext_req_n,
   output phase_e phase,
   output logic   arb_en
);
   phase_e phase_nx;

   assign arb_en = free && ((phase == PH_OWNED) || (phase == PH_RECLAIM));

   always_comb begin
      phase_nx = phase;
      unique case (phase)
         PH_OWNED, PH_RECLAIM: begin
            if (arb_en) phase_nx = ext_win ? PH_PREP : PH_OWNED;
         end
         PH_PREP: phase_nx = PH_LENT;
         PH_LENT: if (ext_req_n) phase_nx = PH_RECLAIM;
         default: phase_nx = PH_OWNED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= PH_OWNED;
      else        phase <= phase_nx;
   end
endmodule

// File: rtl/bus_arb_top.sv
module bus_arb_top
   import bus_arb_pkg::*;
#(
   parameter int unsigned N_MASTERS = 5,
   parameter int unsigned N_CH      = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 refresh_req,
   input  logic                 ext_req_n,
   input  logic [N_CH-1:0]      edma_req,
   input  logic [N_CH-1:0]      dma_req,
   input  logic                 dma_rr_mode,
   input  logic                 bus_busy,
   input  logic                 bus_lock,
   output logic [N_MASTERS-1:0] grant,
   output logic                 edma_ch,
   output logic                 dma_ch,
   output logic                 ext_ack_n,
   output logic                 bus_oe,
   output logic                 strobe_neg
);
   localparam logic [N_MASTERS-1:0] RESET_GRANT = N_MASTERS'(1) << IDX_CPU;

   if (N_MASTERS != OWNER_N) begin : g_bad_masters
      $error("bus_arb_top: N_MASTERS must equal the fixed owner count");
   end
   if (N_CH != 2) begin : g_bad_ch
      $error("bus_arb_top: each DMA engine must have exactly two channels");
   end

   logic [N_MASTERS-1:0] req_vec;
   logic [N_MASTERS-1:0] win;
   logic                 free;
   logic                 arb_en;
   phase_e               phase;

   always_comb begin
      req_vec           = '0;
      req_vec[IDX_CPU]  = 1'b1;
      req_vec[IDX_DMA]  = |dma_req;
      req_vec[IDX_EDMA] = |edma_req;
      req_vec[IDX_EXT]  = ~ext_req_n;
      req_vec[IDX_REF]  = refresh_req;
   end

   assign free = ~bus_busy & ~bus_lock;

   bus_arb_prio #(.N(N_MASTERS)) u_prio (
      .req (req_vec),
      .win (win)
   );

   bus_arb_ext_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .free      (free),
      .ext_win   (win[IDX_EXT]),
      .ext_req_n (ext_req_n),
      .phase     (phase),
      .arb_en    (arb_en)
   );

   bus_arb_pair_sel #(.ALTERNATE_ONLY(1'b1), .RESET_CH(1'b0)) u_edma_sel (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (arb_en & win[IDX_EDMA]),
      .req    (edma_req),
      .rotate (1'b1),
      .ch     (edma_ch)
   );

   bus_arb_pair_sel #(.ALTERNATE_ONLY(1'b0), .RESET_CH(1'b0)) u_dma_sel (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (arb_en & win[IDX_DMA]),
      .req    (dma_req),
      .rotate (dma_rr_mode),
      .ch     (dma_ch)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      grant <= RESET_GRANT;
      else if (arb_en) grant <= win;
   end

   assign ext_ack_n  = (phase != PH_LENT);
   assign bus_oe     = (phase == PH_OWNED) || (phase == PH_RECLAIM);
   assign strobe_neg = (phase != PH_OWNED);
endmodule

// File: rtl/bus_arb_chk.sv
module bus_arb_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       refresh_req,
   input logic       ext_req_n,
   input logic [1:0] edma_req,
   input logic [1:0] dma_req,
   input logic       dma_rr_mode,
   input logic       bus_busy,
   input logic       bus_lock,
   input logic [4:0] grant,
   input logic       edma_ch,
   input logic       dma_ch,
   input logic       ext_ack_n,
   input logic       bus_oe,
   input logic       strobe_neg
);
   logic arb_pt;
   assign arb_pt = bus_oe && !bus_busy && !bus_lock;

   assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(grant) == 1);

   assert_refresh_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_pt && refresh_req) |=> grant[4]);

   assert_cpu_default_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_pt && !refresh_req && ext_req_n && edma_req == 2'b00 && dma_req == 2'b00)
      |=> grant[0]);

   assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_busy || bus_lock) |=> $stable(grant));

   assert_lock_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_lock |=> ($stable(edma_ch) && $stable(dma_ch)));

   assert_edma_alt_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_pt && !refresh_req && ext_req_n && edma_req == 2'b11)
      |=> (edma_ch != $past(edma_ch)));

   assert_dma_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_pt && !refresh_req && ext_req_n && edma_req == 2'b00 &&
       dma_req == 2'b11 && !dma_rr_mode) |=> !dma_ch);

   assert_ack_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_ack_n |-> (!bus_oe && strobe_neg && grant[3]));

   assert_ack_after_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ext_ack_n) |-> $past(!bus_oe));

   assert_resume_negated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_oe) |-> (strobe_neg && ext_ack_n));

   assert_lent_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_oe) |=> grant[3]);
endmodule

bind bus_arb_top bus_arb_chk u_chk (.*);

// File: tb/sim_bus_arb_top.sv
`timescale 1ns/100ps
module sim_bus_arb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       refresh_req = 1'b0;
   logic       ext_req_n = 1'b1;
   logic [1:0] edma_req = 2'b00;
   logic [1:0] dma_req = 2'b00;
   logic       dma_rr_mode = 1'b0;
   logic       bus_busy = 1'b0;
   logic       bus_lock = 1'b0;
   logic [4:0] grant;
   logic       edma_ch, dma_ch, ext_ack_n, bus_oe, strobe_neg;

   int    n_cmp = 0;
   int    n_bad = 0;
   int    cyc = 0;
   string tag = "R1";

   // reference state: owner index, handover phase (0 own,1 prep,2 lent,3 reclaim)
   int m_owner = 0;
   int m_phase = 0;
   int m_ech = 0;
   int m_dch = 0;

   always #2.5 clk = ~clk;

   bus_arb_top u0 (
      .clk(clk), .rst_n(rst_n), .refresh_req(refresh_req), .ext_req_n(ext_req_n),
      .edma_req(edma_req), .dma_req(dma_req), .dma_rr_mode(dma_rr_mode),
      .bus_busy(bus_busy), .bus_lock(bus_lock), .grant(grant), .edma_ch(edma_ch),
      .dma_ch(dma_ch), .ext_ack_n(ext_ack_n), .bus_oe(bus_oe), .strobe_neg(strobe_neg)
   );

   function automatic int pick_owner();
      if (refresh_req)     return 4;
      if (!ext_req_n)      return 3;
      if (edma_req != 0)   return 2;
      if (dma_req != 0)    return 1;
      return 0;
   endfunction

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         m_owner <= 0; m_phase <= 0; m_ech <= 0; m_dch <= 0;
      end else begin
         if ((m_phase == 0 || m_phase == 3) && !bus_busy && !bus_lock) begin
            automatic int w = pick_owner();
            m_owner <= w;
            m_phase <= (w == 3) ? 1 : 0;
            if (w == 2) m_ech <= (edma_req == 2'b11) ? 1 - m_ech : int'(edma_req[1]);
            if (w == 1) m_dch <= (dma_req == 2'b11) ? (dma_rr_mode ? 1 - m_dch : 0)
                                                   : int'(dma_req[1]);
         end else if (m_phase == 1) begin
            m_phase <= 2;
         end else if (m_phase == 2 && ext_req_n) begin
            m_phase <= 3;
         end
      end
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL watchdog (%s) actual cycle=%0d expected below 150000", tag, cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   always @(negedge clk) begin
      if (cyc >= 1) begin
         automatic logic [4:0] e_grant = 5'(1) << m_owner;
         automatic logic [9:0] exp_v = {e_grant, 1'(m_ech), 1'(m_dch),
                                        1'(m_phase != 2),
                                        1'(m_phase == 0 || m_phase == 3),
                                        1'(m_phase != 0)};
         automatic logic [9:0] act_v = {grant, edma_ch, dma_ch, ext_ack_n, bus_oe, strobe_neg};
         n_cmp++;
         if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s cycle %0d actual=%b expected=%b (grant,ech,dch,ack_n,oe,sneg)",
                     tag, cyc, act_v, exp_v);
         end
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic clr();
      refresh_req = 0; ext_req_n = 1; edma_req = 0; dma_req = 0;
      bus_busy = 0; bus_lock = 0;
   endtask

   initial begin
      tag = "R1"; idle(3); rst_n = 1; idle(3);
      // R3: nothing requested
      tag = "R3"; idle(4);
      // R2: everything at once, then peel the top off
      tag = "R2";
      refresh_req = 1; ext_req_n = 0; edma_req = 2'b01; dma_req = 2'b10; idle(2);
      ext_req_n = 1; idle(2); refresh_req = 0; idle(2); edma_req = 0; idle(2);
      clr(); idle(2);
      // R4: busy holds the owner until the cycle ends
      tag = "R4";
      bus_busy = 1; dma_req = 2'b01; idle(3); bus_busy = 0; idle(2);
      bus_busy = 1; refresh_req = 1; idle(2); bus_busy = 0; idle(1); clr(); idle(2);
      // R5: lock across a long sequence
      tag = "R5";
      edma_req = 2'b10; idle(1); bus_lock = 1; refresh_req = 1; edma_req = 2'b11;
      dma_req = 2'b11; idle(5); bus_lock = 0; idle(2); clr(); idle(2);
      // R6: alternation, then single channel
      tag = "R6";
      edma_req = 2'b11; idle(5); edma_req = 2'b01; idle(2); edma_req = 2'b10; idle(2);
      clr(); idle(1);
      // R7: fixed order
      tag = "R7";
      dma_rr_mode = 0; dma_req = 2'b11; idle(3); dma_req = 2'b10; idle(2); dma_req = 2'b11;
      idle(2); clr(); idle(1);
      // R8: rotating order
      tag = "R8";
      dma_rr_mode = 1; dma_req = 2'b11; idle(5); dma_req = 2'b01; idle(1); dma_req = 2'b11;
      idle(2); clr(); idle(1);
      // R9: handover to the outside device
      tag = "R9";
      ext_req_n = 0; idle(4);
      // R11: other activity while lent
      tag = "R11";
      refresh_req = 1; edma_req = 2'b11; bus_busy = 1; idle(2); bus_lock = 1; idle(2);
      // R10: return, held off by busy, then free
      tag = "R10";
      ext_req_n = 1; idle(3); bus_busy = 0; bus_lock = 0; refresh_req = 0; idle(1);
      edma_req = 0; idle(3);
      // random mix
      tag = "R2";
      for (int k = 0; k < 3000; k++) begin
         automatic int r = $urandom_range(0, 99);
         refresh_req = (r < 8);
         edma_req    = 2'($urandom_range(0, 3));
         dma_req     = 2'($urandom_range(0, 3));
         dma_rr_mode = ((k / 200) % 2) == 1;
         bus_busy    = ($urandom_range(0, 99) < 30);
         bus_lock    = ($urandom_range(0, 99) < 15);
         if (ext_req_n) ext_req_n = !($urandom_range(0, 99) < 5);
         else           ext_req_n = ($urandom_range(0, 99) < 15);
         idle(1);
      end
      clr(); idle(6);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule